// File: doc/BRIEF.md
# Prefill Read Controller

This controller sits next to a sample FIFO and its consumer and turns the FIFO into a delay line of programmable length. It keeps its own tally of samples held in the FIFO, adding one on each write and removing one on each read it issues. No read is issued until the tally reaches a threshold that can be changed at run time. From then on it reads whenever the tally is at or above the threshold. With one write per cycle, the output therefore trails the input by exactly the threshold in cycles.

The tally and the compare live in the same clock as the read strobe. The FIFO's own fill-level query is never used. A run enable starts and stops the controller, and dropping it discards the tally. An output-valid flag follows each read strobe by one cycle, which matches a FIFO with a registered read port.

Top module: `prefill_rd_ctrl`

## Requirements
- R1: While rst_ni is low, rd_o, primed_o and valid_o are all 0, whatever the other inputs do.
- R2: rd_o stays 0 in any cycle where the tally is below thresh_i. The tally is the number of writes accepted since run_i last rose, minus the reads issued since then.
- R3: rd_o is 1 in a cycle exactly when run_i is 1, empty_i is 0, the tally is nonzero and the tally is greater than or equal to thresh_i.
- R4: With run_i high, empty_i low and wr_i high every cycle from a tally of zero, the first rd_o comes thresh_i cycles after the first write. A read then occurs every cycle.
- R5: In a cycle with both wr_i and rd_o high, the tally does not change.
- R6: A cycle with run_i low clears the tally and primed_o, and rd_o is 0 in that cycle.
- R7: rd_o is never 1 while empty_i is 1, even after priming.
- R8: If thresh_i is raised above the tally while running, reads stop until writes bring the tally up to the new value.
- R9: valid_o is 1 in the cycle after a cycle with rd_o high, and 0 otherwise.
- R10: primed_o rises in the cycle after the tally first meets the condition in R3 without the empty term. It stays high until run_i is low, even if thresh_i is later raised.
- R11: With thresh_i at 0, reads happen only while the tally is nonzero, so the tally never wraps below zero.
- R12: The tally saturates at 2^CNT_W-1. Writes beyond that are dropped from the count, so a later drain issues exactly 2^CNT_W-1 reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Run enable; low clears tally and primed flag |
| wr_i | input | 1 | Sample written into the FIFO this cycle |
| empty_i | input | 1 | FIFO reports empty |
| thresh_i | input | CNT_W | Delay length in samples |
| rd_o | output | 1 | Read strobe to the FIFO |
| primed_o | output | 1 | Threshold has been reached since run began |
| valid_o | output | 1 | FIFO read data valid, one cycle after rd_o |

## Verification
The gate is driven with a steady write stream, which separates a correct latency of thresh_i cycles from an off-by-one in the compare. A burst followed by silence shows that reads stop once the tally drops below the threshold. A threshold raised mid-stream and a forced-empty window separate a gate that keys on the compare from one that keys on the sticky primed flag or ignores empty_i. A zero threshold, a run-enable drop and an overfill with a full drain then exercise the edge cases: underflow, clearing, and saturation of the tally.

// File: rtl/prefill_pkg.sv
package prefill_pkg;
  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_INC  = 2'd1,
    CNT_DEC  = 2'd2,
    CNT_CLR  = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/prefill_occ_cnt.sv
module prefill_occ_cnt
  import prefill_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cnt_op_e          op_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else begin
      unique case (op_i)
        CNT_INC:  cnt_o <= cnt_o + 1'b1;
        CNT_DEC:  cnt_o <= cnt_o - 1'b1;
        CNT_CLR:  cnt_o <= '0;
        default:  cnt_o <= cnt_o;
      endcase
    end
  end

  p_no_underflow_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == CNT_DEC) |-> (cnt_o != '0));
  p_clr_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == CNT_CLR) |=> (cnt_o == '0));
endmodule

// File: rtl/prefill_rd_gate.sv
module prefill_rd_gate #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             empty_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] thresh_i,
  output logic             rd_o,
  output logic             primed_o
);
  logic at_level;

  // nonzero guard keeps thresh 0 from reading an empty tally
  assign at_level = (cnt_i >= thresh_i) && (cnt_i != '0);
  assign rd_o     = run_i && !empty_i && at_level;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             primed_o <= 1'b0;
    else if (!run_i)         primed_o <= 1'b0;
    else if (at_level)       primed_o <= 1'b1;
  end

  p_primed_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && primed_o) |=> primed_o);
  p_rd_needs_run_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |-> run_i);
endmodule

// File: rtl/prefill_vld_pipe.sv
module prefill_vld_pipe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_i,
  output logic valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= rd_i;
  end

  p_valid_after_rd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> valid_o);
  p_no_spurious_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !valid_o);
endmodule

// File: rtl/prefill_rd_ctrl.sv
module prefill_rd_ctrl
  import prefill_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             wr_i,
  input  logic             empty_i,
  input  logic [CNT_W-1:0] thresh_i,
  output logic             rd_o,
  output logic             primed_o,
  output logic             valid_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;
  cnt_op_e          cnt_op;

  always_comb begin
    if (!run_i)                              cnt_op = CNT_CLR;
    else if (wr_i && !rd_o && cnt != CNT_MAX) cnt_op = CNT_INC;
    else if (rd_o && !wr_i)                  cnt_op = CNT_DEC;
    else                                     cnt_op = CNT_HOLD;
  end

  prefill_occ_cnt #(.CNT_W(CNT_W)) i_occ_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .op_i  (cnt_op),
    .cnt_o (cnt)
  );

  prefill_rd_gate #(.CNT_W(CNT_W)) i_rd_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_i),
    .empty_i (empty_i),
    .cnt_i   (cnt),
    .thresh_i(thresh_i),
    .rd_o    (rd_o),
    .primed_o(primed_o)
  );

  prefill_vld_pipe i_vld_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_i   (rd_o),
    .valid_o(valid_o)
  );

  p_no_rd_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |-> !empty_i);
  p_below_thresh_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt < thresh_i) |-> !rd_o);
  p_hold_on_both_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && wr_i && rd_o) |=> (cnt == $past(cnt)));
  p_run_low_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt == '0 && !primed_o));
  p_saturate_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cnt == CNT_MAX && !rd_o) |=> (cnt == CNT_MAX));
endmodule

// File: tb/test_prefill_rd_ctrl.sv
module test_prefill_rd_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;
  localparam int CMAX = (1 << CNT_W) - 1;

  typedef struct {
    logic  rd;
    logic  primed;
    logic  valid;
    string tag;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             run_i = 1'b1;
  logic             wr_i = 1'b1;
  logic             empty_i = 1'b0;
  logic [CNT_W-1:0] thresh_i = '0;
  logic             rd_o, primed_o, valid_o;

  int   n_checks = 0;
  int   n_fails  = 0;
  exp_t exp_q[$];

  int   m_cnt = 0;
  logic m_primed = 1'b0;
  logic m_prev_rd = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prefill_rd_ctrl #(.CNT_W(CNT_W)) i_prefill_rd_ctrl (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .run_i   (run_i),
    .wr_i    (wr_i),
    .empty_i (empty_i),
    .thresh_i(thresh_i),
    .rd_o    (rd_o),
    .primed_o(primed_o),
    .valid_o (valid_o)
  );

  function automatic void check_bit(string tag, string what, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  // driver: applies one cycle of stimulus and queues the expected outputs
  task automatic step(input logic wr, input logic empty, input logic run,
                      input int thr, input string tag);
    exp_t e;
    logic exp_rd;
    @(negedge clk);
    wr_i = wr; empty_i = empty; run_i = run; thresh_i = thr[CNT_W-1:0];
    #1;
    exp_rd   = run && !empty && (m_cnt >= thr) && (m_cnt != 0);
    e.rd     = exp_rd;
    e.primed = m_primed;
    e.valid  = m_prev_rd;
    e.tag    = tag;
    exp_q.push_back(e);
    if (!run) begin
      m_cnt = 0; m_primed = 1'b0;
    end else begin
      if (m_cnt >= thr && m_cnt != 0) m_primed = 1'b1;
      if (wr && !exp_rd && m_cnt < CMAX) m_cnt++;
      else if (exp_rd && !wr) m_cnt--;
    end
    m_prev_rd = exp_rd;
  endtask

  // monitor: pops and compares after outputs settle
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check_bit(e.tag, "rd_o", rd_o, e.rd);
        check_bit(e.tag, "primed_o", primed_o, e.primed);
        check_bit(e.tag, "valid_o", valid_o, e.valid);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int first_rd;
    // R1: outputs quiet while reset held, inputs active
    repeat (3) @(posedge clk);
    #2;
    check_bit("R1", "rd_o", rd_o, 1'b0);
    check_bit("R1", "primed_o", primed_o, 1'b0);
    check_bit("R1", "valid_o", valid_o, 1'b0);
    @(negedge clk);
    run_i = 1'b0; wr_i = 1'b0;
    rst_ni = 1'b1;

    repeat (2) step(0, 0, 0, 3, "R6");
    // R4: steady stream, thresh 3; first read 3 cycles after first write
    first_rd = -1;
    for (int i = 0; i < 12; i++) begin
      step(1, 0, 1, 3, "R4");
      #2;
      if (rd_o && first_rd < 0) first_rd = i;
    end
    n_checks++;
    if (first_rd != 3) begin
      n_fails++;
      $display("FAIL R4 first read cycle: actual %0d expected 3", first_rd);
    end
    // R2/R3: stop writing, reads drain one then stop below threshold
    repeat (4) step(0, 0, 1, 3, "R2");
    // R5: wr and rd together keep tally, reads continue
    repeat (5) step(1, 0, 1, 3, "R5");
    // R8: raise threshold, reads pause until tally catches up
    repeat (6) step(1, 0, 1, 6, "R8");
    // R10: primed stays high across raise; R7: empty blocks reads
    repeat (3) step(1, 1, 1, 6, "R7");
    repeat (3) step(0, 0, 1, 6, "R3");
    // R6: run low clears tally and primed
    repeat (2) step(1, 0, 0, 2, "R6");
    repeat (3) step(1, 0, 1, 2, "R10");
    repeat (2) step(0, 0, 0, 0, "R6");
    // R11: zero threshold never reads an empty tally
    repeat (2) step(0, 0, 1, 0, "R11");
    step(1, 0, 1, 0, "R11");
    repeat (3) step(0, 0, 1, 0, "R11");
    // R12: overfill with reads blocked, then full drain
    repeat (CMAX + 5) step(1, 1, 1, CMAX, "R12");
    repeat (CMAX + 5) step(0, 0, 1, 1, "R12");
    step(0, 0, 1, 1, "R12");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule